// File: doc/BRIEF.md
# Shared-Supply DVFS Level Selector

This block chooses a single voltage/frequency level that every core of a small multicore runs at during the next management interval (nominally 10 ms). At the end of an interval the surrounding logic presents, for each core, the power and throughput measured over that interval and the level the core was running at. It also presents the chip-wide power budget. A start pulse then launches a search.

For each candidate level, the block projects every core's measurement to that level. Power scales with the cube of the voltage ratio between the candidate level and the core's own previous level. Throughput scales linearly with that same ratio. The ratios are fixed-point constants computed at elaboration. Candidates are examined from the fastest level downward, one core per clock. The first level whose projected chip power stays within the budget is reported, together with the projected chip power and throughput at that level.

Top module: `dvfs_chipwide_sel`

## Requirements
- R1: Levels are coded 1 to 7, with level l meaning a supply of (0.65 + 0.05*l) V. The cubic factor for candidate c and previous level p is round(4096*(v(c)/v(p))^3). The linear factor is round(4096*v(c)/v(p)). Both are rounded to nearest with ties upward (Q4.12).
- R2: A core's projected power at a candidate level is floor(power_sample * cubic_factor / 4096). The reported total power is the sum over all cores at the chosen level.
- R3: A core's projected throughput is floor(throughput_sample * linear_factor / 4096). The reported total throughput is the sum over all cores at the chosen level.
- R4: Candidates are tried from 7 down to 1. The chosen level is the highest one whose total projected power is less than or equal to the budget, so equality counts as fitting.
- R5: If even level 1 exceeds the budget, the result is level 1 with `over_budget_o` = 1 and the level-1 totals. Otherwise `over_budget_o` = 0.
- R6: When level k is chosen, `done_o` is high for exactly one cycle, (8-k)*NUM_CORES clock edges after the edge that samples `start_i`. Inputs are held stable from start until done.
- R7: The level, totals and `over_budget_o` change only in the cycle where `done_o` is high. They hold their values at all other times.
- R8: A `start_i` pulse that arrives while a search is in progress has no effect on that search, its result or its timing.
- R9: After reset, `done_o` = 0, `level_o` = 1, both totals are 0 and `over_budget_o` = 0.
- R10: With every sample at its maximum value and every core moving from level 1 to level 7, the totals are exact and do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search (ignored while busy) |
| budget_i | input | ACC_W | Chip power budget, same units as the power samples |
| pwr_smp_i | input | NUM_CORES x PWR_W | Power measured per core over the last interval |
| thr_smp_i | input | NUM_CORES x THR_W | Throughput measured per core over the last interval |
| prev_lvl_i | input | NUM_CORES x 3 | Level each core ran at during the last interval |
| done_o | output | 1 | One-cycle result strobe |
| level_o | output | 3 | Chosen shared level |
| pwr_total_o | output | ACC_W | Projected chip power at the chosen level |
| thr_total_o | output | TACC_W | Projected chip throughput at the chosen level |
| over_budget_o | output | 1 | No level fits the budget |

## Verification
Each level the search rejects costs NUM_CORES cycles. The result for level k therefore arrives (8-k)*NUM_CORES edges after the start edge. Every run in the bench counts the edges from the start edge to `done_o` and compares that count with the figure predicted from the level its reference model chooses. Outputs are sampled on the falling clock edge of the strobe cycle. Holding and ignored-start behaviour are checked by sampling the outputs a few cycles after a result and again after a start issued mid-search.

// File: rtl/dvfs_sel_pkg.sv
package dvfs_sel_pkg;
    localparam int LVL_W   = 3;
    localparam int NUM_LVL = 7;
    localparam int FRAC    = 12;
    localparam int RAT_W   = 16;

    function automatic longint volt_cent(input int lvl);
        int l;
        l = (lvl < 1) ? 1 : ((lvl > NUM_LVL) ? NUM_LVL : lvl);
        return 65 + 5 * l;
    endfunction

    function automatic logic [RAT_W-1:0] cube_ratio(input int cand, input int prev);
        longint vc, vp, num, den;
        vc  = volt_cent(cand);
        vp  = volt_cent(prev);
        num = vc * vc * vc * (longint'(1) << FRAC);
        den = vp * vp * vp;
        return RAT_W'((num + den / 2) / den);
    endfunction

    function automatic logic [RAT_W-1:0] lin_ratio(input int cand, input int prev);
        longint vc, vp;
        vc = volt_cent(cand);
        vp = volt_cent(prev);
        return RAT_W'((vc * (longint'(1) << FRAC) + vp / 2) / vp);
    endfunction
endpackage

// File: rtl/dvfs_ratio_table.sv
module dvfs_ratio_table
    import dvfs_sel_pkg::*;
(
    input  logic [LVL_W-1:0] cand_i,
    input  logic [LVL_W-1:0] prev_i,
    output logic [RAT_W-1:0] cube_o,
    output logic [RAT_W-1:0] lin_o
);
    localparam int ENT = 1 << LVL_W;

    logic [RAT_W-1:0] cube_tab [ENT][ENT];
    logic [RAT_W-1:0] lin_tab  [ENT][ENT];

    for (genvar c = 0; c < ENT; c++) begin : g_cand
        for (genvar p = 0; p < ENT; p++) begin : g_prev
            assign cube_tab[c][p] = cube_ratio(c, p);
            assign lin_tab[c][p]  = lin_ratio(c, p);
        end
    end

    assign cube_o = cube_tab[cand_i][prev_i];
    assign lin_o  = lin_tab[cand_i][prev_i];
endmodule

// File: rtl/dvfs_core_est.sv
module dvfs_core_est
    import dvfs_sel_pkg::*;
#(
    parameter int PWR_W = 16,
    parameter int THR_W = 16,
    localparam int EP_W = PWR_W + 2,
    localparam int ET_W = THR_W + 1
) (
    input  logic [PWR_W-1:0] pwr_i,
    input  logic [THR_W-1:0] thr_i,
    input  logic [RAT_W-1:0] cube_i,
    input  logic [RAT_W-1:0] lin_i,
    output logic [EP_W-1:0]  est_pwr_o,
    output logic [ET_W-1:0]  est_thr_o
);
    localparam int PP_W = PWR_W + RAT_W;
    localparam int TP_W = THR_W + RAT_W;

    logic [PP_W-1:0] p_prod;
    logic [TP_W-1:0] t_prod;

    assign p_prod    = PP_W'(pwr_i) * PP_W'(cube_i);
    assign t_prod    = TP_W'(thr_i) * TP_W'(lin_i);
    assign est_pwr_o = p_prod[FRAC +: EP_W];
    assign est_thr_o = t_prod[FRAC +: ET_W];
endmodule

// File: rtl/dvfs_chipwide_sel.sv
module dvfs_chipwide_sel
    import dvfs_sel_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int PWR_W     = 16,
    parameter int THR_W     = 16,
    localparam int CNT_W    = $clog2(NUM_CORES + 1),
    localparam int ACC_W    = PWR_W + 2 + CNT_W,
    localparam int TACC_W   = THR_W + 1 + CNT_W
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             start_i,
    input  logic [ACC_W-1:0]                 budget_i,
    input  logic [NUM_CORES-1:0][PWR_W-1:0]  pwr_smp_i,
    input  logic [NUM_CORES-1:0][THR_W-1:0]  thr_smp_i,
    input  logic [NUM_CORES-1:0][LVL_W-1:0]  prev_lvl_i,
    output logic                             done_o,
    output logic [LVL_W-1:0]                 level_o,
    output logic [ACC_W-1:0]                 pwr_total_o,
    output logic [TACC_W-1:0]                thr_total_o,
    output logic                             over_budget_o
);
    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam int EP_W  = PWR_W + 2;
    localparam int ET_W  = THR_W + 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CORES - 1);
    localparam logic [LVL_W-1:0] TOP_LVL  = LVL_W'(NUM_LVL);
    localparam logic [LVL_W-1:0] BOT_LVL  = LVL_W'(1);

    typedef struct packed {
        logic               busy;
        logic [LVL_W-1:0]   cand;
        logic [IDX_W-1:0]   core;
        logic [ACC_W-1:0]   pacc;
        logic [TACC_W-1:0]  tacc;
        logic               done;
        logic [LVL_W-1:0]   level;
        logic [ACC_W-1:0]   ptot;
        logic [TACC_W-1:0]  ttot;
        logic               over;
    } sel_state_t;

    sel_state_t st_d, st_q;

    logic [PWR_W-1:0]  cur_pwr;
    logic [THR_W-1:0]  cur_thr;
    logic [LVL_W-1:0]  cur_prev;
    logic [RAT_W-1:0]  cube_f, lin_f;
    logic [EP_W-1:0]   est_pwr;
    logic [ET_W-1:0]   est_thr;
    logic [ACC_W-1:0]  psum;
    logic [TACC_W-1:0] tsum;
    logic              busy_q;

    assign cur_pwr  = pwr_smp_i[st_q.core];
    assign cur_thr  = thr_smp_i[st_q.core];
    assign cur_prev = prev_lvl_i[st_q.core];

    dvfs_ratio_table u_tab (
        .cand_i (st_q.cand),
        .prev_i (cur_prev),
        .cube_o (cube_f),
        .lin_o  (lin_f)
    );

    dvfs_core_est #(.PWR_W(PWR_W), .THR_W(THR_W)) u_est (
        .pwr_i     (cur_pwr),
        .thr_i     (cur_thr),
        .cube_i    (cube_f),
        .lin_i     (lin_f),
        .est_pwr_o (est_pwr),
        .est_thr_o (est_thr)
    );

    assign psum = st_q.pacc + ACC_W'(est_pwr);
    assign tsum = st_q.tacc + TACC_W'(est_thr);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.cand = TOP_LVL;
                st_d.core = '0;
                st_d.pacc = '0;
                st_d.tacc = '0;
            end
        end else if (st_q.core == LAST_IDX) begin
            if ((psum <= budget_i) || (st_q.cand == BOT_LVL)) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.level = st_q.cand;
                st_d.ptot  = psum;
                st_d.ttot  = tsum;
                st_d.over  = (psum > budget_i);
            end else begin
                st_d.cand = st_q.cand - BOT_LVL;
                st_d.core = '0;
                st_d.pacc = '0;
                st_d.tacc = '0;
            end
        end else begin
            st_d.core = st_q.core + IDX_W'(1);
            st_d.pacc = psum;
            st_d.tacc = tsum;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.cand  <= TOP_LVL;
            st_q.level <= BOT_LVL;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_q        = st_q.busy;
    assign done_o        = st_q.done;
    assign level_o       = st_q.level;
    assign pwr_total_o   = st_q.ptot;
    assign thr_total_o   = st_q.ttot;
    assign over_budget_o = st_q.over;
endmodule

// File: rtl/dvfs_sel_chk.sv
module dvfs_sel_chk #(
    parameter int ACC_W  = 21,
    parameter int TACC_W = 20
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              busy_q,
    input logic [ACC_W-1:0]  budget_i,
    input logic              done_o,
    input logic [2:0]        level_o,
    input logic [ACC_W-1:0]  pwr_total_o,
    input logic [TACC_W-1:0] thr_total_o,
    input logic              over_budget_o
);
    // R1
    level_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (level_o != 3'd0) && (level_o <= 3'd7));

    // R5
    over_at_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        over_budget_o |-> (level_o == 3'd1));

    // R4
    fits_budget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !over_budget_o) |-> (pwr_total_o <= budget_i));

    // R7
    hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(level_o) && $stable(pwr_total_o)
                     && $stable(thr_total_o) && $stable(over_budget_o)));

    // R6
    done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(busy_q));

    // R6
    idle_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_q || $past(!busy_q));
endmodule

bind dvfs_chipwide_sel dvfs_sel_chk #(.ACC_W(ACC_W), .TACC_W(TACC_W)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .busy_q        (busy_q),
    .budget_i      (budget_i),
    .done_o        (done_o),
    .level_o       (level_o),
    .pwr_total_o   (pwr_total_o),
    .thr_total_o   (thr_total_o),
    .over_budget_o (over_budget_o)
);

// File: tb/tb_dvfs_chipwide_sel.sv
module tb_dvfs_chipwide_sel;
    localparam int N    = 4;
    localparam int PW   = 16;
    localparam int TW   = 16;
    localparam int AW   = PW + 2 + $clog2(N + 1);
    localparam int TAW  = TW + 1 + $clog2(N + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] budget = '0;
    logic [N-1:0][PW-1:0] pwr = '0;
    logic [N-1:0][TW-1:0] thr = '0;
    logic [N-1:0][2:0] prv = '0;
    logic done, over;
    logic [2:0] lvl;
    logic [AW-1:0] ptot;
    logic [TAW-1:0] ttot;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dvfs_chipwide_sel #(.NUM_CORES(N), .PWR_W(PW), .THR_W(TW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .budget_i(budget),
        .pwr_smp_i(pwr), .thr_smp_i(thr), .prev_lvl_i(prv),
        .done_o(done), .level_o(lvl), .pwr_total_o(ptot),
        .thr_total_o(ttot), .over_budget_o(over)
    );

    typedef struct packed {
        logic [N-1:0][PW-1:0] p;
        logic [N-1:0][TW-1:0] t;
        logic [N-1:0][2:0]    l;
        logic [AW-1:0]        b;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{ {16'd1000, 16'd1000, 16'd1000, 16'd1000}, {16'd500, 16'd500, 16'd500, 16'd500},
           {3'd7, 3'd7, 3'd7, 3'd7}, 21'd4000 },
        '{ {16'd1000, 16'd1000, 16'd1000, 16'd1000}, {16'd500, 16'd500, 16'd500, 16'd500},
           {3'd7, 3'd7, 3'd7, 3'd7}, 21'd3999 },
        '{ {16'd2000, 16'd1500, 16'd800, 16'd300}, {16'd900, 16'd700, 16'd400, 16'd200},
           {3'd4, 3'd5, 3'd2, 3'd7}, 21'd5000 },
        '{ {16'd4000, 16'd4000, 16'd4000, 16'd4000}, {16'd1000, 16'd1200, 16'd1400, 16'd1600},
           {3'd1, 3'd1, 3'd1, 3'd1}, 21'd30000 },
        '{ {16'd3000, 16'd3000, 16'd3000, 16'd3000}, {16'd800, 16'd800, 16'd800, 16'd800},
           {3'd1, 3'd3, 3'd5, 3'd7}, 21'd6000 },
        '{ {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF}, {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
           {3'd1, 3'd1, 3'd1, 3'd1}, 21'h1FFFFF }
    };

    // Reference model built from R1..R5
    function automatic longint ref_v(input int l);
        return 65 + 5 * l;
    endfunction
    function automatic longint ref_cube(input int c, input int p);
        longint n, d;
        n = ref_v(c) ** 3 * 4096;
        d = ref_v(p) ** 3;
        return (n + d / 2) / d;
    endfunction
    function automatic longint ref_lin(input int c, input int p);
        return (ref_v(c) * 4096 + ref_v(p) / 2) / ref_v(p);
    endfunction

    int e_lvl; longint e_p, e_t; bit e_over;

    task automatic model();
        e_over = 1'b0;
        for (int c = 7; c >= 1; c--) begin
            e_p = 0; e_t = 0;
            for (int k = 0; k < N; k++) begin
                e_p += (longint'(pwr[k]) * ref_cube(c, int'(prv[k]))) / 4096;
                e_t += (longint'(thr[k]) * ref_lin(c, int'(prv[k]))) / 4096;
            end
            e_lvl = c;
            if (e_p <= longint'(budget)) return;
        end
        e_over = 1'b1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    int lat;
    task automatic run_search(input bit extra_start);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        lat = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            lat++;
            if (extra_start && lat == 2) start = 1'b1;
            else start = 1'b0;
            if (done) break;
        end
        start = 1'b0;
    endtask

    task automatic check_result(input string tag);
        model();
        chk(done === 1'b1, "R6", {tag, " done seen"}, done, 1);
        chk(lat == (8 - e_lvl) * N, "R6", {tag, " latency"}, lat, (8 - e_lvl) * N);
        chk(int'(lvl) == e_lvl, "R4", {tag, " level"}, lvl, e_lvl);
        chk(longint'(ptot) == e_p, "R2", {tag, " power total"}, ptot, e_p);
        chk(longint'(ttot) == e_t, "R3", {tag, " throughput total"}, ttot, e_t);
        chk(over == e_over, "R5", {tag, " over flag"}, over, e_over);
        @(negedge clk);
        chk(done == 1'b0, "R6", {tag, " done one cycle"}, done, 0);
    endtask

    initial begin
        #3_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(done == 1'b0 && lvl == 3'd1 && ptot == '0 && ttot == '0 && over == 1'b0,
            "R9", "reset outputs", {lvl, done, over}, 3'd1 << 2);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            pwr = VECS[v].p; thr = VECS[v].t; prv = VECS[v].l; budget = VECS[v].b;
            run_search(1'b0);
            check_result($sformatf("vec%0d", v));
        end
        // R10 last vector: maximum samples from level 1 projected to level 7
        chk(lvl == 3'd7 && ptot == AW'(4 * ((longint'(65535) * ref_cube(7, 1)) / 4096)),
            "R10", "max sample total", ptot, 4 * ((longint'(65535) * ref_cube(7, 1)) / 4096));
        // R1 a factor checked through a single-core-active projection
        pwr = '0; thr = '0; prv = {3'd7, 3'd7, 3'd7, 3'd4}; pwr[0] = 16'd4096; thr[0] = 16'd4096;
        budget = 21'd4096;
        run_search(1'b0);
        check_result("factor");
        chk(longint'(ptot) == ref_cube(lvl, 4), "R1", "cubic factor visible", ptot, ref_cube(lvl, 4));

        // R5 zero budget with nonzero load
        pwr = {16'd10, 16'd20, 16'd30, 16'd40}; thr = {16'd5, 16'd5, 16'd5, 16'd5};
        prv = {3'd2, 3'd3, 3'd4, 3'd5}; budget = '0;
        run_search(1'b0);
        check_result("zero budget");

        // R7 results held after done
        repeat (5) @(negedge clk);
        chk(lvl == 3'd1 && over == 1'b1 && longint'(ptot) == e_p, "R7", "hold after done", ptot, e_p);

        // R8 second start during a search is ignored
        pwr = VECS[2].p; thr = VECS[2].t; prv = VECS[2].l; budget = VECS[2].b;
        run_search(1'b1);
        check_result("restart ignored R8");
        repeat (4) @(negedge clk);
        chk(done == 1'b0, "R8", "no second result", done, 0);

        // R4 zero load fits a zero budget at the top level
        pwr = '0; thr = '0; prv = {3'd1, 3'd2, 3'd6, 3'd7}; budget = '0;
        run_search(1'b0);
        check_result("zero load");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule